// File: doc/BRIEF.md
# CD-ROM Data Sector Descrambler and Checker

This block sits between a CD decoder's byte output and the sector buffer of a CD-ROM controller. It watches the incoming byte stream for the 12-byte sync field that opens every 2352-byte data sector. Every later byte of the sector is bit-reversed and then XORed with a key from a 15-bit scrambling LFSR, which turns it back into plain sector data. The plain bytes leave on a valid/ready stream, each with the error flag that came in with it. The stream carries data only when collection was enabled at the moment the sync completed.

The four header bytes (minutes, seconds, frames, mode) are always captured, with or without collection. Header-ready and header-error flags go with them. The Mode 2 sub-header supplies the form. The block runs the 32-bit CD-ROM error-detection code over the region that the sector's mode and form select. When the last byte of the sector is accepted, it issues one status byte on a single-cycle strobe.

Back-pressure: a byte is accepted on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low only while an output byte is held and `out_ready` is low. A held output byte, and its flag, stay unchanged until `out_ready` takes them. Bytes that are not forwarded, such as sync bytes and bytes of sectors that are not collected, are still accepted at full rate under the same rule.

Top module: `cdsec_sector_checker`

## Requirements
- R1: A sector starts when the accepted raw bytes form 0x00, ten bytes of 0xFF, 0x00. The byte after that last 0x00 is sector position 12. A mismatching byte restarts the search, and that byte counts as a new first 0x00 if it is 0x00.
- R2: For positions 12 to 2351, the plain byte is bitrev(in_data) XOR key. In bitrev, bit i moves to bit 7−i. The key comes from an LFSR with polynomial x^15 + x + 1, loaded with 0x0001 at each sync. Each key bit is the LFSR's low bit before a right shift, and the feedback (bit0 XOR bit1) enters at bit 14. Key bit 0 is the first output, and the LFSR advances 8 steps per byte.
- R3: Plain bytes of positions 12 to 2351 leave on `out_data`, with `out_err` equal to that byte's `in_err`, only if `collect_en` was high on the edge that completed the sync. Changing `collect_en` later has no effect on that sector.
- R4: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. An output byte is held, unchanged, while `out_ready` is low. No byte is lost or duplicated.
- R5: Positions 12, 13, 14 and 15 load `hdr_min`, `hdr_sec`, `hdr_frm` and `hdr_mode`. `hdr_ready` rises after position 15 and clears at the next sync. Capture happens whether or not `collect_en` is high.
- R6: `hdr_error` is set with `hdr_ready` if any header byte carried `in_err`, or if the mode byte is greater than 2.
- R7: The EDC is the reflected form of x^32+x^31+x^16+x^15+x^4+x^3+x+1. It is fed LSB first, starts at zero and has no final XOR. Mode 1 covers plain positions 0 to 2067, with the stored code little-endian at 2064 to 2067. The sector passes when the remainder is zero.
- R8: For mode 2, the form is bit 5 of plain position 18 (set = Form 2). Form 1 covers positions 16 to 2075. Form 2, mode 0 and invalid modes are not checked and never report a CRC failure.
- R9: In the cycle after position 2351 is accepted, `stat_valid` is high for exactly one cycle. `stat_byte` then holds: bit0 CRC fail, bit1 header error, bits3:2 mode[1:0], bit4 Form 2, bit5 any flagged byte, bit6 CRC checked, bit7 zero.
- R10: A sync that completes in the middle of a sector ends that sector without a status byte and starts a new one.
- R11: The any-flagged status bit is set if any byte from position 12 to 2351 carried `in_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| collect_en | input | 1 | Enables forwarding of the sector whose sync completes next |
| in_valid | input | 1 | Raw byte available |
| in_ready | output | 1 | Block can accept a raw byte |
| in_data | input | 8 | Raw byte from the decoder |
| in_err | input | 1 | Decoder error flag for the raw byte |
| out_valid | output | 1 | Plain byte available |
| out_ready | input | 1 | Consumer takes the plain byte |
| out_data | output | 8 | Plain sector byte |
| out_err | output | 1 | Error flag of the plain byte |
| hdr_min | output | 8 | Header minutes |
| hdr_sec | output | 8 | Header seconds |
| hdr_frm | output | 8 | Header frames |
| hdr_mode | output | 8 | Header mode |
| hdr_ready | output | 1 | Header registers hold this sector's header |
| hdr_error | output | 1 | Header flagged or mode invalid |
| stat_valid | output | 1 | One-cycle status strobe |
| stat_byte | output | 8 | Sector status byte |

## Verification
The assertions take for granted only that the consumer may drop or raise `out_ready` in any cycle, and that a sector is much longer than one byte, so two status strobes can never be adjacent. They place no condition on the raw data. The stimulus holds each raw byte and its flag steady until it is accepted, and it stalls `out_ready` in a repeating pattern during some sectors. The random payload bytes are assumed never to form a raw sync pattern by accident, which the mid-sector restart check depends on.

// File: rtl/cdsec_pkg.sv
package cdsec_pkg;

  localparam int SYNC_LEN   = 12;
  localparam int HDR_LEN    = 4;
  localparam int SUBHDR_LEN = 8;
  localparam int EDC_LEN    = 4;
  localparam int FORM_BIT   = 5;
  localparam int LFSR_W     = 15;
  localparam logic [LFSR_W-1:0] LFSR_SEED = LFSR_W'(1);
  localparam logic [31:0] EDC_POLY_R = 32'hD801_8001;

  typedef struct packed {
    logic       rsvd;
    logic       crc_checked;
    logic       any_flag;
    logic       form2;
    logic [1:0] mode;
    logic       hdr_err;
    logic       crc_fail;
  } sec_status_t;

  function automatic logic [7:0] bit_rev(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_adv8(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    t = s;
    for (int i = 0; i < 8; i++) t = {t[0] ^ t[1], t[LFSR_W-1:1]};
    return t;
  endfunction

  function automatic logic [31:0] edc_update(input logic [31:0] c, input logic [7:0] b,
                                             input logic [31:0] poly);
    logic [31:0] t;
    t = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) t = t[0] ? ((t >> 1) ^ poly) : (t >> 1);
    return t;
  endfunction

  function automatic logic [7:0] sync_pattern(input int idx);
    return (idx == 0 || idx == SYNC_LEN - 1) ? 8'h00 : 8'hFF;
  endfunction

  function automatic logic [31:0] edc_sync_seed();
    logic [31:0] c;
    c = '0;
    for (int i = 0; i < SYNC_LEN; i++) c = edc_update(c, sync_pattern(i), EDC_POLY_R);
    return c;
  endfunction

endpackage

// File: rtl/cdsec_sync_detect.sv
module cdsec_sync_detect
  import cdsec_pkg::*;
#(
  parameter int PAT_LEN = SYNC_LEN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic [7:0] byte_in,
  output logic       hit
);
  localparam int CW = $clog2(PAT_LEN);
  localparam logic [CW-1:0] LAST = CW'(PAT_LEN - 1);

  logic [CW-1:0] idx;
  logic [7:0]    want;

  always_comb want = (idx == '0 || idx == LAST) ? 8'h00 : 8'hFF;
  always_comb hit  = take && (idx == LAST) && (byte_in == 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (take) begin
      if (byte_in == want) idx <= (idx == LAST) ? '0 : idx + CW'(1);
      else                 idx <= (byte_in == 8'h00) ? CW'(1) : '0;
    end
  end
endmodule

// File: rtl/cdsec_descrambler.sv
module cdsec_descrambler
  import cdsec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       step,
  output logic [7:0] key
);
  logic [LFSR_W-1:0] state;

  always_comb key = state[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= LFSR_SEED;
    else if (load) state <= LFSR_SEED;
    else if (step) state <= lfsr_adv8(state);
  end
endmodule

// File: rtl/cdsec_edc.sv
module cdsec_edc
  import cdsec_pkg::*;
#(
  parameter logic [31:0] POLY = EDC_POLY_R
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] seed,
  input  logic        step,
  input  logic        fresh,
  input  logic [7:0]  byte_in,
  output logic [31:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= '0;
    else if (load) crc <= seed;
    else if (step) crc <= edc_update(fresh ? 32'd0 : crc, byte_in, POLY);
  end
endmodule

// File: rtl/cdsec_sector_checker.sv
module cdsec_sector_checker
  import cdsec_pkg::*;
#(
  parameter int SECTOR_BYTES = 2352,
  parameter int USER_BYTES   = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       collect_en,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_err,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_err,
  output logic [7:0] hdr_min,
  output logic [7:0] hdr_sec,
  output logic [7:0] hdr_frm,
  output logic [7:0] hdr_mode,
  output logic       hdr_ready,
  output logic       hdr_error,
  output logic       stat_valid,
  output logic [7:0] stat_byte
);
  localparam int POS_W = $clog2(SECTOR_BYTES);
  typedef logic [POS_W-1:0] pos_t;

  localparam pos_t P_MIN    = pos_t'(SYNC_LEN);
  localparam pos_t P_SEC    = pos_t'(SYNC_LEN + 1);
  localparam pos_t P_FRM    = pos_t'(SYNC_LEN + 2);
  localparam pos_t P_MODE   = pos_t'(SYNC_LEN + 3);
  localparam pos_t P_SUB    = pos_t'(SYNC_LEN + HDR_LEN);
  localparam pos_t P_FORM   = pos_t'(SYNC_LEN + HDR_LEN + 2);
  localparam pos_t P_M1_END = pos_t'(SYNC_LEN + HDR_LEN + USER_BYTES + EDC_LEN - 1);
  localparam pos_t P_M2_END = pos_t'(SYNC_LEN + HDR_LEN + SUBHDR_LEN + USER_BYTES + EDC_LEN - 1);
  localparam pos_t P_LAST   = pos_t'(SECTOR_BYTES - 1);
  localparam logic [31:0] SYNC_SEED = edc_sync_seed();

  logic        take, hit, sb;
  logic [7:0]  key, desc;
  logic        in_sec, collecting, hdr_flag_q, any_q, form2_q;
  pos_t        pos, crc_end;
  logic [31:0] crc;
  logic        crc_step, crc_fresh;
  sec_status_t st;

  always_comb begin
    in_ready = !out_valid || out_ready;
    take     = in_valid && in_ready;
    sb       = take && in_sec && !hit;
    desc     = bit_rev(in_data) ^ key;
  end

  cdsec_sync_detect #(.PAT_LEN(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .take(take), .byte_in(in_data), .hit(hit)
  );

  cdsec_descrambler u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(hit), .step(sb), .key(key)
  );

  // EDC region bound picked by the mode captured at position 15
  always_comb begin
    crc_end   = (hdr_mode == 8'd1) ? P_M1_END : P_M2_END;
    crc_step  = sb && (pos <= crc_end);
    crc_fresh = (pos == P_SUB) && (hdr_mode != 8'd1);
  end

  cdsec_edc #(.POLY(EDC_POLY_R)) u_edc (
    .clk(clk), .rst_n(rst_n), .load(hit), .seed(SYNC_SEED), .step(crc_step),
    .fresh(crc_fresh), .byte_in(desc), .crc(crc)
  );

  // sequencer: position, header capture, flag accumulation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sec     <= 1'b0;
      pos        <= '0;
      collecting <= 1'b0;
      hdr_min    <= '0;
      hdr_sec    <= '0;
      hdr_frm    <= '0;
      hdr_mode   <= '0;
      hdr_ready  <= 1'b0;
      hdr_error  <= 1'b0;
      hdr_flag_q <= 1'b0;
      any_q      <= 1'b0;
      form2_q    <= 1'b0;
    end else if (hit) begin
      in_sec     <= 1'b1;
      pos        <= P_MIN;
      collecting <= collect_en;
      hdr_ready  <= 1'b0;
      hdr_error  <= 1'b0;
      hdr_flag_q <= 1'b0;
      any_q      <= 1'b0;
      form2_q    <= 1'b0;
    end else if (sb) begin
      any_q <= any_q | in_err;
      if (pos <= P_MODE) hdr_flag_q <= hdr_flag_q | in_err;
      if (pos == P_MIN) hdr_min <= desc;
      if (pos == P_SEC) hdr_sec <= desc;
      if (pos == P_FRM) hdr_frm <= desc;
      if (pos == P_MODE) begin
        hdr_mode  <= desc;
        hdr_ready <= 1'b1;
        hdr_error <= hdr_flag_q | in_err | (desc > 8'd2);
      end
      if (pos == P_FORM) form2_q <= (hdr_mode == 8'd2) & desc[FORM_BIT];
      if (pos == P_LAST) in_sec <= 1'b0;
      else               pos    <= pos + pos_t'(1);
    end
  end

  always_comb begin
    st.rsvd        = 1'b0;
    st.crc_checked = (hdr_mode == 8'd1) || ((hdr_mode == 8'd2) && !form2_q);
    st.crc_fail    = st.crc_checked && (crc != 32'd0);
    st.hdr_err     = hdr_error;
    st.mode        = hdr_mode[1:0];
    st.form2       = form2_q;
    st.any_flag    = any_q | in_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_byte  <= '0;
    end else begin
      stat_valid <= sb && (pos == P_LAST);
      if (sb && (pos == P_LAST)) stat_byte <= st;
    end
  end

  // single output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else if (sb && collecting) begin
      out_valid <= 1'b1;
      out_data  <= desc;
      out_err   <= in_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cdsec_checker.sv
module cdsec_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_err,
  input logic       hdr_ready,
  input logic       hdr_error,
  input logic [7:0] hdr_mode,
  input logic       stat_valid,
  input logic [7:0] stat_byte
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_err));

  assert_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_badmode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ready && (hdr_mode > 8'd2) |-> hdr_error);

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);

  assert_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> !stat_byte[7]);

  assert_checked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && stat_byte[0] |-> stat_byte[6]);
endmodule

bind cdsec_sector_checker cdsec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_err(out_err),
  .hdr_ready(hdr_ready), .hdr_error(hdr_error), .hdr_mode(hdr_mode),
  .stat_valid(stat_valid), .stat_byte(stat_byte)
);

// File: tb/sim_cdsec_sector_checker.sv
module sim_cdsec_sector_checker;
  localparam int NB = 2352;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       collect_en = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_err = 1'b0;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid, out_err, hdr_ready, hdr_error, stat_valid;
  logic [7:0] out_data, hdr_min, hdr_sec, hdr_frm, hdr_mode, stat_byte;

  cdsec_sector_checker u0 (
    .clk(clk), .rst_n(rst_n), .collect_en(collect_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_err(in_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_err(out_err),
    .hdr_min(hdr_min), .hdr_sec(hdr_sec), .hdr_frm(hdr_frm), .hdr_mode(hdr_mode),
    .hdr_ready(hdr_ready), .hdr_error(hdr_error), .stat_valid(stat_valid), .stat_byte(stat_byte)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] plain [NB];
  logic [7:0] raw   [NB];
  logic       flg   [NB];
  logic [7:0] obuf  [4096];
  logic       oerrb [4096];
  int         ocnt = 0;
  logic [7:0] sbuf  [16];
  int         scnt = 0;
  bit         bp_on = 1'b0;
  int         cyc = 0;
  logic [31:0] rnd = 32'h1234_5678;

  always @(negedge clk) begin
    cyc++;
    out_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
  end

  always @(negedge clk) begin
    #2;
    if (out_valid && out_ready) begin
      if (ocnt < 4096) begin obuf[ocnt] = out_data; oerrb[ocnt] = out_err; end
      ocnt++;
    end
    if (stat_valid) begin
      if (scnt < 16) sbuf[scnt] = stat_byte;
      scnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [31:0] edc_calc(input int lo, input int hi);
    logic [31:0] c = 32'd0;
    for (int i = lo; i <= hi; i++)
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = c[0] ^ plain[i][j];
        c = c >> 1;
        if (fb) c = c ^ 32'hD801_8001;
      end
    return c;
  endfunction

  task automatic build(input logic [7:0] mode, input bit form2, input bit corrupt);
    logic [31:0] e;
    logic [14:0] s;
    for (int i = 0; i < NB; i++) begin
      rnd = rnd * 32'd1664525 + 32'd1013904223;
      plain[i] = rnd[23:16];
      flg[i] = 1'b0;
    end
    for (int i = 0; i < 12; i++) plain[i] = (i == 0 || i == 11) ? 8'h00 : 8'hFF;
    plain[12] = 8'h12; plain[13] = 8'h34; plain[14] = 8'h56; plain[15] = mode;
    if (mode == 8'd2)
      for (int k = 0; k < 2; k++) begin
        plain[16+4*k] = 8'h00; plain[17+4*k] = 8'h00;
        plain[18+4*k] = form2 ? 8'h20 : 8'h08; plain[19+4*k] = 8'h00;
      end
    if (mode == 8'd1) begin
      e = edc_calc(0, 2063);
      for (int k = 0; k < 4; k++) plain[2064+k] = e[8*k +: 8];
    end
    if (mode == 8'd2 && !form2) begin
      e = edc_calc(16, 2071);
      for (int k = 0; k < 4; k++) plain[2072+k] = e[8*k +: 8];
    end
    if (corrupt) plain[1000] = plain[1000] ^ 8'h10;
    s = 15'h0001;
    for (int i = 0; i < NB; i++) begin
      logic [7:0] key = 8'h00;
      if (i >= 12)
        for (int b = 0; b < 8; b++) begin
          key[b] = s[0];
          s = {s[0] ^ s[1], s[14:1]};
        end
      raw[i] = (i >= 12) ? rev8(plain[i] ^ key) : plain[i];
    end
  endtask

  task automatic send_range(input int lo, input int hi);
    bit acc;
    for (int i = lo; i <= hi; i++) begin
      in_valid = 1'b1; in_data = raw[i]; in_err = flg[i];
      do begin
        #1 acc = in_ready;
        @(negedge clk);
      end while (!acc);
    end
    in_valid = 1'b0; in_err = 1'b0;
  endtask

  task automatic send_noise(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = 8'h5A; in_err = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic clear_caps();
    repeat (8) @(negedge clk);
    ocnt = 0; scnt = 0;
  endtask

  task automatic drain();
    repeat (10) @(negedge clk);
  endtask

  task automatic check_sector(input bit exp_out, input logic [7:0] exp_st,
                              input string rq_data, input string rq_st);
    int exp_n = exp_out ? NB - 12 : 0;
    int bad = 0;
    chk(ocnt == exp_n, rq_data, "output byte count", ocnt, exp_n);
    if (exp_out && ocnt == exp_n)
      for (int i = 0; i < exp_n; i++)
        if (obuf[i] !== plain[12+i] || oerrb[i] !== flg[12+i]) bad++;
    chk(bad == 0, rq_data, "plain bytes/flags mismatching", bad, 0);
    chk(scnt == 1, "R9", "status strobes", scnt, 1);
    chk(sbuf[0] === exp_st, rq_st, "status byte", int'(sbuf[0]), int'(exp_st));
  endtask

  task automatic check_hdr(input logic [7:0] mode, input bit err, input string rq);
    chk(hdr_ready === 1'b1, "R5", "hdr_ready", int'(hdr_ready), 1);
    chk({hdr_min, hdr_sec, hdr_frm, hdr_mode} === {24'h123456, mode}, "R5", "header regs",
        int'({hdr_min, hdr_sec, hdr_frm, hdr_mode}), int'({24'h123456, mode}));
    chk(hdr_error === err, rq, "hdr_error", int'(hdr_error), int'(err));
  endtask

  task automatic t_reset();
    chk(in_ready === 1'b1, "R4", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid === 1'b0, "R3", "out_valid after reset", int'(out_valid), 0);
    chk(stat_valid === 1'b0, "R9", "stat_valid after reset", int'(stat_valid), 0);
    chk(hdr_ready === 1'b0, "R5", "hdr_ready after reset", int'(hdr_ready), 0);
  endtask

  // R1 R2 R7: clean Mode 1 sector after noise
  task automatic t_mode1_good();
    clear_caps(); collect_en = 1'b1; build(8'd1, 1'b0, 1'b0);
    send_noise(5); send_range(0, NB-1); drain();
    check_sector(1'b1, 8'h44, "R2", "R7");
    check_hdr(8'd1, 1'b0, "R6");
  endtask

  // R7 R4: corrupt Mode 1 under output stalls
  task automatic t_mode1_bad();
    clear_caps(); bp_on = 1'b1; build(8'd1, 1'b0, 1'b1);
    send_range(0, NB-1); drain(); bp_on = 1'b0; drain();
    check_sector(1'b1, 8'h45, "R4", "R7");
  endtask

  task automatic t_m2f1(input bit corrupt);
    clear_caps(); bp_on = corrupt; build(8'd2, 1'b0, corrupt);
    send_range(0, NB-1); drain(); bp_on = 1'b0; drain();
    check_sector(1'b1, corrupt ? 8'h49 : 8'h48, "R4", "R8");
  endtask

  task automatic t_m2f2();
    clear_caps(); build(8'd2, 1'b1, 1'b1);
    send_range(0, NB-1); drain();
    check_sector(1'b1, 8'h18, "R2", "R8");
  endtask

  task automatic t_hdr_flag();
    clear_caps(); build(8'd1, 1'b0, 1'b0); flg[13] = 1'b1;
    send_range(0, NB-1); drain();
    check_sector(1'b1, 8'h66, "R3", "R6");
    check_hdr(8'd1, 1'b1, "R6");
  endtask

  task automatic t_data_flag();
    clear_caps(); build(8'd1, 1'b0, 1'b0); flg[500] = 1'b1;
    send_range(0, NB-1); drain();
    check_sector(1'b1, 8'h64, "R3", "R11");
  endtask

  task automatic t_bad_mode();
    clear_caps(); build(8'd3, 1'b0, 1'b0);
    send_range(0, NB-1); drain();
    check_sector(1'b1, 8'h0E, "R2", "R6");
    check_hdr(8'd3, 1'b1, "R6");
  endtask

  // R3 R5: header and status without collection
  task automatic t_no_collect();
    clear_caps(); collect_en = 1'b0; build(8'd1, 1'b0, 1'b0);
    send_range(0, NB-1); drain();
    check_sector(1'b0, 8'h44, "R3", "R7");
    check_hdr(8'd1, 1'b0, "R5");
  endtask

  // R3: collect_en dropped after sync has no effect
  task automatic t_late_drop();
    clear_caps(); collect_en = 1'b1; build(8'd1, 1'b0, 1'b0);
    send_range(0, 20); collect_en = 1'b0; send_range(21, NB-1); drain();
    check_sector(1'b1, 8'h44, "R3", "R7");
  endtask

  // R10: partial sector then a new sync
  task automatic t_abort();
    clear_caps(); collect_en = 1'b0; build(8'd1, 1'b0, 1'b0);
    send_range(0, 1000);
    chk(hdr_ready === 1'b1, "R5", "hdr_ready in partial sector", int'(hdr_ready), 1);
    build(8'd1, 1'b0, 1'b0); collect_en = 1'b1;
    send_range(0, 13);
    chk(hdr_ready === 1'b0, "R5", "hdr_ready after new sync", int'(hdr_ready), 0);
    chk(scnt == 0, "R10", "status from aborted sector", scnt, 0);
    send_range(14, NB-1); drain();
    check_sector(1'b1, 8'h44, "R10", "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode1_good();
    t_mode1_bad();
    t_m2f1(1'b0);
    t_m2f1(1'b1);
    t_m2f2();
    t_hdr_flag();
    t_data_flag();
    t_bad_mode();
    t_no_collect();
    t_late_drop();
    t_abort();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule